// File: doc/BRIEF.md
# Page-Local Non-Unit Stride Detector

This block watches the stream of cache misses and looks for a constant distance between successive misses that land in the same memory page. It keeps a small table of entries. Each entry is identified by the page its stored line belongs to, and it records three things: the line seen most recently in that page, the distance from the miss before it, and how many times in a row that distance has repeated. A stride engine downstream uses the allocate pulse and its signed stride, counted in lines, to start a new prefetch stream.

Each miss goes through one table search. A miss in a page the table does not know takes an entry in round-robin order. A miss in a known page either trains the entry or, once the same nonzero distance has been seen often enough, requests a stream and clears the entry. A miss to the same line as the stored one is ignored. The line size, page size, table depth and training threshold are parameters.

Top module: `nonunit_stride_filter`

## Requirements
- R1: After reset, hit_o, alloc_o and alloc_stride_o are 0. Every entry holds line address 0, delta 0 and count 0, and the round-robin pointer is 0. A fresh table therefore matches page 0 in entry 0.
- R2: A miss is presented as miss_valid=1 with miss_addr and is reported on hit_o, alloc_o and alloc_stride_o in the following clock cycle. In a cycle after one with miss_valid=0, hit_o and alloc_o are 0.
- R3: The line of an address is the address with its low log2(LINE_BYTES) bits (6 by default) cleared. Its page is the address bits above log2(PAGE_BYTES) (bit 12 and up by default). The search selects the lowest-indexed entry whose stored line is in the same page as the miss. The delta is the miss line minus the stored line, as a signed byte count.
- R4: A matched miss with delta 0 reports no hit and no allocate. It changes no entry and inserts nothing.
- R5: A matched miss with a nonzero delta reports hit_o=1. If the delta equals the stored delta, the count increments; otherwise the count becomes 0. In both cases the entry then stores the new delta and the new line.
- R6: When an incremented count exceeds TRAIN_THRESH (default 4), alloc_o pulses for one cycle with hit_o=1, and alloc_stride_o = delta / LINE_BYTES. The entry is then cleared to line 0, delta 0 and count 0. A freshly inserted entry allocates on the seventh miss of a constant stride.
- R7: A miss that matches no entry reports hit_o=0. It loads the entry at the round-robin pointer with its line, delta 0 and count 0, and the pointer advances by one, wrapping from NUM_ENTRIES-1 to 0.
- R8: alloc_stride_o is 0 in every cycle in which alloc_o is 0.
- R9: Negative strides are detected and reported as a negative two's complement line count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| miss_valid | input | 1 | A cache miss is presented this cycle |
| miss_addr | input | ADDR_W | Byte address of the miss |
| hit_o | output | 1 | Previous miss matched a page with a nonzero delta |
| alloc_o | output | 1 | One-cycle request to start a stream |
| alloc_stride_o | output | log2(PAGE_BYTES)-log2(LINE_BYTES)+1 | Signed stride in lines, valid with alloc_o |

## Verification
Several properties are checked on every cycle: an allocate always comes with a hit and a nonzero stride, the stride output is quiet without an allocate, nothing is reported after an idle cycle, the selected entry really matches, no count grows past the threshold, and the pointer advances only on an insert, with wraparound. Whether the right entry was trained, reset or replaced can only be seen across scenarios. These scenarios are: positive and negative stride trains, an interrupted train whose count must restart, a same-line miss that must leave the entry alive, an eviction order that shows the pointer wrapping, and the page-0 aliasing of a freshly reset table.

// File: rtl/sf_pkg.sv
package sf_pkg;
  // What the table does with the miss presented in a cycle.
  typedef enum logic [2:0] {
    SF_IDLE,    // no miss
    SF_SKIP,    // page matched, zero delta
    SF_INSERT,  // no page matched, new entry
    SF_TRAIN,   // page matched, nonzero delta, below threshold
    SF_ALLOC    // threshold passed, request stream
  } sf_event_e;
endpackage

// File: rtl/sf_page_match.sv
module sf_page_match #(
  parameter int N      = 8,
  parameter int PAGE_W = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0][PAGE_W-1:0] tags,
  input  logic [PAGE_W-1:0]      page,
  output logic                   any_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [N-1:0] eq;
  logic [N-1:0] sel;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign eq[i] = (tags[i] == page);
  end

  // Lowest index wins.
  always_comb begin
    sel   = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) begin
        sel   = '0;
        sel[i] = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
  assign any_o = |eq;

  // R3: the chosen entry is a real page match and the selection is single.
  a_r3_sel_matches: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (eq[idx_o] && $onehot0(sel)));
  a_r3_sel_present: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (sel != '0));
endmodule

// File: rtl/sf_rr_ptr.sv
module sf_rr_ptr #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_o <= '0;
    else if (advance) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

  // R7: one step per insert, wrapping at the last entry; held otherwise.
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> ptr_o == (($past(ptr_o) == LAST) ? '0 : $past(ptr_o) + 1'b1));
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(ptr_o));
endmodule

// File: rtl/nonunit_stride_filter.sv
module nonunit_stride_filter
  import sf_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int NUM_ENTRIES  = 8,
  parameter int LINE_BYTES   = 64,
  parameter int PAGE_BYTES   = 4096,
  parameter int TRAIN_THRESH = 4,
  localparam int LINE_SH  = $clog2(LINE_BYTES),
  localparam int PAGE_SH  = $clog2(PAGE_BYTES),
  localparam int STRIDE_W = PAGE_SH - LINE_SH + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       miss_valid,
  input  logic [ADDR_W-1:0]          miss_addr,
  output logic                       hit_o,
  output logic                       alloc_o,
  output logic signed [STRIDE_W-1:0] alloc_stride_o
);
  localparam int DELTA_W = PAGE_SH + 1;
  localparam int PAGE_W  = ADDR_W - PAGE_SH;
  localparam int CNT_W   = $clog2(TRAIN_THRESH + 2);
  localparam int IDX_W   = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_SH) - 1'b1);

  // ---- arithmetic helpers ----
  function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a & LINE_MASK;
  endfunction

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_SH];
  endfunction

  // Both lines sit in one page, so the low DELTA_W bits of the
  // full difference are the exact signed byte distance.
  function automatic logic signed [DELTA_W-1:0] delta_of(
      input logic [ADDR_W-1:0] now_line, input logic [ADDR_W-1:0] old_line);
    logic [ADDR_W-1:0] diff;
    diff = now_line - old_line;
    return DELTA_W'(diff);
  endfunction

  function automatic logic signed [STRIDE_W-1:0] stride_of(
      input logic signed [DELTA_W-1:0] d);
    return STRIDE_W'(d >>> LINE_SH);
  endfunction

  // ---- table state ----
  logic [ADDR_W-1:0]         ent_line  [NUM_ENTRIES];
  logic signed [DELTA_W-1:0] ent_delta [NUM_ENTRIES];
  logic [CNT_W-1:0]          ent_cnt   [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0][PAGE_W-1:0] tags;
  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) tags[i] = page_of(ent_line[i]);
  end

  // ---- search ----
  logic [ADDR_W-1:0]         in_line;
  logic                      m_any;
  logic [IDX_W-1:0]          m_idx;
  logic [IDX_W-1:0]          rr_ptr;
  logic signed [DELTA_W-1:0] cur_delta;
  logic                      same_delta;
  logic [CNT_W-1:0]          cnt_inc;
  sf_event_e                 ev;

  assign in_line = line_of(miss_addr);

  sf_page_match #(.N(NUM_ENTRIES), .PAGE_W(PAGE_W)) u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .tags  (tags),
    .page  (page_of(miss_addr)),
    .any_o (m_any),
    .idx_o (m_idx)
  );

  sf_rr_ptr #(.N(NUM_ENTRIES)) u_rr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (ev == SF_INSERT),
    .ptr_o   (rr_ptr)
  );

  assign cur_delta  = delta_of(in_line, ent_line[m_idx]);
  assign same_delta = (cur_delta == ent_delta[m_idx]);
  assign cnt_inc    = ent_cnt[m_idx] + 1'b1;

  always_comb begin
    if (!miss_valid)                                      ev = SF_IDLE;
    else if (!m_any)                                      ev = SF_INSERT;
    else if (cur_delta == '0)                             ev = SF_SKIP;
    else if (same_delta && int'(cnt_inc) > TRAIN_THRESH)  ev = SF_ALLOC;
    else                                                  ev = SF_TRAIN;
  end

  // ---- entry update ----
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic chosen;
    assign chosen = (m_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_line[i]  <= '0;
        ent_delta[i] <= '0;
        ent_cnt[i]   <= '0;
      end else if (ev == SF_INSERT && rr_ptr == IDX_W'(i)) begin
        ent_line[i]  <= in_line;
        ent_delta[i] <= '0;
        ent_cnt[i]   <= '0;
      end else if (ev == SF_TRAIN && chosen) begin
        ent_line[i]  <= in_line;
        ent_delta[i] <= cur_delta;
        ent_cnt[i]   <= same_delta ? cnt_inc : '0;
      end else if (ev == SF_ALLOC && chosen) begin
        ent_line[i]  <= '0;
        ent_delta[i] <= '0;
        ent_cnt[i]   <= '0;
      end
    end

    // R5: a count never survives past the threshold.
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ent_cnt[i]) <= TRAIN_THRESH);
  end

  // ---- registered outputs ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_o          <= 1'b0;
      alloc_o        <= 1'b0;
      alloc_stride_o <= '0;
    end else begin
      hit_o          <= (ev == SF_TRAIN) || (ev == SF_ALLOC);
      alloc_o        <= (ev == SF_ALLOC);
      alloc_stride_o <= (ev == SF_ALLOC) ? stride_of(cur_delta) : '0;
    end
  end

  // R6: an allocate is also a hit and carries a nonzero stride.
  a_r6_alloc_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_o |-> hit_o);
  a_r6_stride_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_o |-> alloc_stride_o != '0);
  // R6: allocate is a single-cycle pulse unless another miss follows.
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_o && !miss_valid) |=> !alloc_o);
  // R8: stride output quiet without allocate.
  a_r8_stride_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_o |-> alloc_stride_o == '0);
  // R2: nothing reported after an idle cycle.
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_valid |=> (!hit_o && !alloc_o));
  // R4: a same-line miss reports nothing.
  a_r4_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == SF_SKIP) |=> !hit_o);
endmodule

// File: tb/nonunit_stride_filter_test.sv
`timescale 1ns/1ps
module nonunit_stride_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        hit_o;
  logic        alloc_o;
  logic signed [6:0] alloc_stride_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  nonunit_stride_filter uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_valid     (miss_valid),
    .miss_addr      (miss_addr),
    .hit_o          (hit_o),
    .alloc_o        (alloc_o),
    .alloc_stride_o (alloc_stride_o)
  );

  // {addr[41:10], hit[9], alloc[8], stride[7:0]}
  localparam int NV = 38;
  localparam logic [41:0] VEC [NV] = '{
    {32'h0001_0000, 1'b0, 1'b0, 8'h00},  // R7 insert e0
    {32'h0001_0080, 1'b1, 1'b0, 8'h00},  // R5 new delta
    {32'h0001_0100, 1'b1, 1'b0, 8'h00},
    {32'h0001_0180, 1'b1, 1'b0, 8'h00},
    {32'h0001_0200, 1'b1, 1'b0, 8'h00},
    {32'h0001_0280, 1'b1, 1'b0, 8'h00},
    {32'h0001_0300, 1'b1, 1'b1, 8'h02},  // R6 +2 lines
    {32'h0001_0301, 1'b0, 1'b0, 8'h00},  // R6 entry cleared -> insert e1
    {32'h0002_0F00, 1'b0, 1'b0, 8'h00},  // insert e2
    {32'h0002_0E40, 1'b1, 1'b0, 8'h00},
    {32'h0002_0D80, 1'b1, 1'b0, 8'h00},
    {32'h0002_0CC0, 1'b1, 1'b0, 8'h00},
    {32'h0002_0C00, 1'b1, 1'b0, 8'h00},
    {32'h0002_0B40, 1'b1, 1'b0, 8'h00},
    {32'h0002_0A80, 1'b1, 1'b1, 8'hFD},  // R9 -3 lines
    {32'h0001_0310, 1'b0, 1'b0, 8'h00},  // R4 same line
    {32'h0001_0340, 1'b1, 1'b0, 8'h00},  // R4 entry survived
    {32'h0001_0380, 1'b1, 1'b0, 8'h00},
    {32'h0001_03C0, 1'b1, 1'b0, 8'h00},
    {32'h0001_0480, 1'b1, 1'b0, 8'h00},  // R5 delta change, count 0
    {32'h0001_0540, 1'b1, 1'b0, 8'h00},
    {32'h0001_0600, 1'b1, 1'b0, 8'h00},
    {32'h0001_06C0, 1'b1, 1'b0, 8'h00},
    {32'h0001_0780, 1'b1, 1'b0, 8'h00},
    {32'h0001_0840, 1'b1, 1'b1, 8'h03},  // R5 retrained, +3 lines
    {32'h0003_0000, 1'b0, 1'b0, 8'h00},  // R7 ptr 3
    {32'h0003_1000, 1'b0, 1'b0, 8'h00},  // ptr 4
    {32'h0003_2000, 1'b0, 1'b0, 8'h00},  // ptr 5
    {32'h0003_3000, 1'b0, 1'b0, 8'h00},  // ptr 6
    {32'h0003_4000, 1'b0, 1'b0, 8'h00},  // ptr 7
    {32'h0003_5000, 1'b0, 1'b0, 8'h00},  // ptr 0 (wrap)
    {32'h0003_1040, 1'b1, 1'b0, 8'h00},  // R3 page match
    {32'h0004_0000, 1'b0, 1'b0, 8'h00},  // ptr 1
    {32'h0004_1000, 1'b0, 1'b0, 8'h00},  // ptr 2
    {32'h0004_2000, 1'b0, 1'b0, 8'h00},  // ptr 3 evicts page 0x30
    {32'h0003_0040, 1'b0, 1'b0, 8'h00},  // R7 evicted: miss, evicts 0x31
    {32'h0003_1080, 1'b0, 1'b0, 8'h00},  // R7 evicted
    {32'h0003_0080, 1'b1, 1'b0, 8'h00}   // R3 reloaded page hits
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Present one miss, then sample the outputs one cycle later.
  task automatic miss(input logic [31:0] a, input string req,
                      input int eh, input int ea, input int es);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    @(negedge clk);
    miss_valid = 1'b0;
    check(req, "hit", int'(hit_o), eh);
    check(req, "alloc", int'(alloc_o), ea);
    check(req, "stride", int'(alloc_stride_o), es);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    miss_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check("R1", "hit", int'(hit_o), 0);
    check("R1", "alloc", int'(alloc_o), 0);
    check("R1", "stride", int'(alloc_stride_o), 0);

    for (int v = 0; v < NV; v++) begin
      miss(VEC[v][41:10], "R3-R9 table", int'(VEC[v][9]), int'(VEC[v][8]),
           int'($signed(VEC[v][7:0])));
    end

    // R2: idle cycle reports nothing
    @(negedge clk);
    check("R2", "hit idle", int'(hit_o), 0);
    check("R2", "alloc idle", int'(alloc_o), 0);

    // R1: fresh table aliases page 0 in entry 0
    do_reset();
    check("R1", "hit after reset", int'(hit_o), 0);
    miss(32'h0000_0000, "R1 R4 zero line", 0, 0, 0);
    miss(32'h0000_0040, "R1 page0 match", 1, 0, 0);
    miss(32'h0000_0080, "R1 page0 train", 1, 0, 0);
    miss(32'h0000_1000, "R7 new page", 0, 0, 0);
    miss(32'h0000_1100, "R5 new entry trains", 1, 0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule